// File: doc/BRIEF.md
# Segmented Virtual Address Translator

This block turns a 16-bit virtual address into a 22-bit physical address. The virtual space is cut into eight 8 KB segments chosen by the top three address bits. Each segment has a base register, which gives the segment's start in 64-byte units, and a descriptor register, which sets the legal length, which way the segment grows and what kind of access it permits. Kernel and user mode each own a set of these registers for instruction fetches and a second set for data, which gives 32 base/descriptor pairs in all.

The register file is loaded over a simple write-only register bus. A global enable switches relocation on. A separation register decides, per mode, whether data accesses use their own register set or share the instruction set. A request carries the virtual address, the mode, the instruction/data selector and a write flag. The registered response one cycle later gives either a physical address or a fault. While relocation is off, addresses pass straight through. The topmost 8 KB of the virtual space is then placed at the top of physical space.

Top module: `vat_top`

## Requirements
- R1: While reset is asserted and after it is released, `rspValid`, `rspFault` and `rspPaddr` are 0. Every base register, descriptor register, the enable bit and both separation bits reset to 0.
- R2: A request with `reqValid` high produces `rspValid` high on the next cycle. A cycle without a request gives `rspValid`, `rspFault` and `rspPaddr` all 0 on the next cycle.
- R3: With relocation off, the response never faults. `rspPaddr` is the virtual address zero-extended, except that virtual addresses 0xE000 and above map to 0x3FE000 plus the low 13 bits.
- R4: With relocation on and the checks passed, `rspPaddr` = (base × 64 + vaddr[12:0]) mod 2^22, using the register pair of segment vaddr[15:13].
- R5: Descriptor bits 14:8 hold the length L and bit 3 the direction. With direction 0, an access whose block number vaddr[12:6] is greater than L faults, so L = 0 still allows 64 bytes.
- R6: With direction 1, an access whose block number is less than L faults, so L = 0x7F allows only the top 64 bytes.
- R7: Descriptor bits 2:0 hold the access code. Codes 5 and 6 allow reads and writes. Codes 1 and 2 allow reads, and a write faults. Codes 0, 3, 4 and 7 fault on any access.
- R8: A faulting request returns `rspFault` = 1 with `rspPaddr` = 0.
- R9: Kernel requests (`reqUser` = 0) and user requests use disjoint register sets.
- R10: Separation register bit 0 (user) and bit 2 (kernel) give data requests their own registers. When a mode's bit is 0, its data requests use that mode's instruction registers.
- R11: Register address bit 6 = 0 selects a pair entry: bit 5 picks descriptor (1) or base (0), bit 4 picks user (1), bit 3 picks data (1), and bits 2:0 pick the segment. Address 0x40 bit 0 is the relocation enable, and address 0x41 is the separation register. A write takes effect on the cycle after it, so a request in the same cycle sees the old value.
- R12: Writes to addresses 0x42 to 0x7F change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 7 | Register write address |
| regWrData | input | 16 | Register write data |
| reqValid | input | 1 | Translation request present |
| reqVaddr | input | 16 | Virtual address |
| reqUser | input | 1 | 1 = user mode, 0 = kernel mode |
| reqData | input | 1 | 1 = data access, 0 = instruction access |
| reqWrite | input | 1 | 1 = write cycle |
| rspValid | output | 1 | Response present |
| rspPaddr | output | 22 | Physical address, 0 on fault |
| rspFault | output | 1 | Length or access violation |

## Verification
A register write and a translation can fall in the same cycle, and the write can hit the very pair, enable bit or separation bit that the translation selects. The bench provokes this on purpose: it rewrites a segment's base while requesting through that segment, and then repeats the request one cycle later. A long random phase also mixes writes and requests freely. The bench model applies each write only after it has predicted that cycle's response. The response must therefore show the old value on the collision cycle and the new one on the next.

// File: rtl/vat_pkg.sv
package vat_pkg;
  localparam int VA_W      = 16;
  localparam int PA_W      = 22;
  localparam int DATA_W    = 16;
  localparam int SEG_W     = 3;
  localparam int BLK_SHIFT = 6;
  localparam int OFF_W     = VA_W - SEG_W;
  localparam int BLK_W     = OFF_W - BLK_SHIFT;
  localparam int IDX_W     = SEG_W + 2;
  localparam int NSETS     = 1 << IDX_W;
  localparam int ADDR_W    = IDX_W + 2;
  localparam int LEN_LSB   = 8;
  localparam int DIR_BIT   = 3;
  localparam int ACC_W     = 3;
  localparam logic [ADDR_W-1:0] EN_ADDR  = ADDR_W'(NSETS * 2);
  localparam logic [ADDR_W-1:0] SEP_ADDR = ADDR_W'(NSETS * 2 + 1);
  localparam int SEP_USER_BIT   = 0;
  localparam int SEP_KERNEL_BIT = 2;

  typedef struct packed {
    logic             parWe;
    logic             pdrWe;
    logic [IDX_W-1:0] wrIdx;
    logic [IDX_W-1:0] rdIdx;
    logic             load;
    logic             fault;
    logic             bypass;
  } vatStrobe_t;
endpackage

// File: rtl/vat_datapath.sv
module vat_datapath
  import vat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  vatStrobe_t        stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [VA_W-1:0]   vaddr,
  output logic [BLK_W-1:0]  selLen,
  output logic              selDir,
  output logic [ACC_W-1:0]  selAcc,
  output logic              rspValid,
  output logic [PA_W-1:0]   rspPaddr,
  output logic              rspFault
);
  logic [DATA_W-1:0] parMem [NSETS];
  logic [DATA_W-1:0] pdrMem [NSETS];
  logic [DATA_W-1:0] parSel;
  logic [DATA_W-1:0] pdrSel;
  logic [PA_W-1:0]   relocAddr;
  logic [PA_W-1:0]   bypassAddr;
  logic [PA_W-1:0]   nextAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NSETS; i++) begin
        parMem[i] <= '0;
        pdrMem[i] <= '0;
      end
    end else begin
      if (stb.parWe) parMem[stb.wrIdx] <= wrData;
      if (stb.pdrWe) pdrMem[stb.wrIdx] <= wrData;
    end
  end

  assign parSel = parMem[stb.rdIdx];
  assign pdrSel = pdrMem[stb.rdIdx];
  assign selLen = pdrSel[LEN_LSB +: BLK_W];
  assign selDir = pdrSel[DIR_BIT];
  assign selAcc = pdrSel[ACC_W-1:0];

  assign relocAddr = (PA_W'(parSel) << BLK_SHIFT) + PA_W'(vaddr[OFF_W-1:0]);

  always_comb begin
    if (&vaddr[VA_W-1:OFF_W])
      bypassAddr = {{(PA_W-OFF_W){1'b1}}, vaddr[OFF_W-1:0]};
    else
      bypassAddr = PA_W'(vaddr);
  end

  always_comb begin
    nextAddr = '0;
    if (stb.load && !stb.fault)
      nextAddr = stb.bypass ? bypassAddr : relocAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspPaddr <= '0;
      rspFault <= 1'b0;
    end else begin
      rspValid <= stb.load;
      rspPaddr <= nextAddr;
      rspFault <= stb.load && stb.fault;
    end
  end
endmodule

// File: rtl/vat_ctrl.sv
module vat_ctrl
  import vat_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWrEn,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic [SEP_KERNEL_BIT:0] wrLow,
  input  logic                    reqValid,
  input  logic [VA_W-1:BLK_SHIFT] vaHigh,
  input  logic                    reqUser,
  input  logic                    reqData,
  input  logic                    reqWrite,
  input  logic [BLK_W-1:0]        selLen,
  input  logic                    selDir,
  input  logic [ACC_W-1:0]        selAcc,
  output vatStrobe_t              stb
);
  logic enReg;
  logic sepUser;
  logic sepKernel;
  logic mapHit;
  logic useD;
  logic [BLK_W-1:0] blkNum;
  logic lenOk;
  logic accOk;

  assign mapHit = regWrEn && !regAddr[ADDR_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg     <= 1'b0;
      sepUser   <= 1'b0;
      sepKernel <= 1'b0;
    end else if (regWrEn) begin
      if (regAddr == EN_ADDR) enReg <= wrLow[0];
      if (regAddr == SEP_ADDR) begin
        sepUser   <= wrLow[SEP_USER_BIT];
        sepKernel <= wrLow[SEP_KERNEL_BIT];
      end
    end
  end

  assign useD   = reqData && (reqUser ? sepUser : sepKernel);
  assign blkNum = vaHigh[OFF_W-1:BLK_SHIFT];

  always_comb begin
    if (selDir) lenOk = (blkNum >= selLen);
    else        lenOk = (blkNum <= selLen);
  end

  always_comb begin
    case (selAcc)
      3'd1, 3'd2: accOk = !reqWrite;
      3'd5, 3'd6: accOk = 1'b1;
      default:    accOk = 1'b0;
    endcase
  end

  always_comb begin
    stb.parWe  = mapHit && !regAddr[ADDR_W-2];
    stb.pdrWe  = mapHit &&  regAddr[ADDR_W-2];
    stb.wrIdx  = regAddr[IDX_W-1:0];
    stb.rdIdx  = {reqUser, useD, vaHigh[VA_W-1:OFF_W]};
    stb.load   = reqValid;
    stb.bypass = !enReg;
    stb.fault  = enReg && !(lenOk && accOk);
  end
endmodule

// File: rtl/vat_top.sv
module vat_top
  import vat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              reqUser,
  input  logic              reqData,
  input  logic              reqWrite,
  output logic              rspValid,
  output logic [PA_W-1:0]   rspPaddr,
  output logic              rspFault
);
  vatStrobe_t       stb;
  logic [BLK_W-1:0] selLen;
  logic             selDir;
  logic [ACC_W-1:0] selAcc;

  vat_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .wrLow    (regWrData[SEP_KERNEL_BIT:0]),
    .reqValid (reqValid),
    .vaHigh   (reqVaddr[VA_W-1:BLK_SHIFT]),
    .reqUser  (reqUser),
    .reqData  (reqData),
    .reqWrite (reqWrite),
    .selLen   (selLen),
    .selDir   (selDir),
    .selAcc   (selAcc),
    .stb      (stb)
  );

  vat_datapath i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (regWrData),
    .vaddr    (reqVaddr),
    .selLen   (selLen),
    .selDir   (selDir),
    .selAcc   (selAcc),
    .rspValid (rspValid),
    .rspPaddr (rspPaddr),
    .rspFault (rspFault)
  );
endmodule

// File: rtl/vat_checker.sv
module vat_checker
  import vat_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              wrBit0,
  input logic              reqValid,
  input logic [OFF_W-1:0]  reqOff,
  input logic              rspValid,
  input logic [PA_W-1:0]   rspPaddr,
  input logic              rspFault
);
  logic enShadow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enShadow <= 1'b0;
    else if (regWrEn && regAddr == EN_ADDR) enShadow <= wrBit0;
  end

  // R8
  p_fault_no_addr_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> rspPaddr == '0);

  // R2
  p_req_answered_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R2
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && !rspFault && rspPaddr == '0));

  // R4
  p_block_offset_kept_r4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (rspFault || rspPaddr[BLK_SHIFT-1:0] == $past(reqOff[BLK_SHIFT-1:0])));

  // R3
  p_bypass_passthru_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !enShadow) |=> (!rspFault && rspPaddr[OFF_W-1:0] == $past(reqOff)));
endmodule

bind vat_top vat_checker i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regAddr  (regAddr),
  .wrBit0   (regWrData[0]),
  .reqValid (reqValid),
  .reqOff   (reqVaddr[vat_pkg::OFF_W-1:0]),
  .rspValid (rspValid),
  .rspPaddr (rspPaddr),
  .rspFault (rspFault)
);

// File: tb/test_vat_top.sv
`timescale 1ns/1ps
module test_vat_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [6:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic        reqValid = 1'b0;
  logic [15:0] reqVaddr = '0;
  logic        reqUser = 1'b0;
  logic        reqData = 1'b0;
  logic        reqWrite = 1'b0;
  logic        rspValid;
  logic [21:0] rspPaddr;
  logic        rspFault;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  int unsigned parM [32];
  int unsigned pdrM [32];
  bit enM, sepU, sepK;

  bit          expV, expF;
  int unsigned expA;
  string       expTag;

  always #2 clk = ~clk;

  vat_top i_vat_top (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .reqUser(reqUser), .reqData(reqData), .reqWrite(reqWrite),
    .rspValid(rspValid), .rspPaddr(rspPaddr), .rspFault(rspFault)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected under 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  function automatic [6:0] mapA(bit pdr, bit u, bit dsp, int seg);
    return {1'b0, pdr, u, dsp, 3'(seg)};
  endfunction

  function automatic void predict(bit rq, int unsigned va, bit u, bit dsp, bit w, string tagIn);
    int unsigned seg, idx, par, pdr, blk, len, acc;
    bit dir, lenOk, accOk;
    expV = rq; expF = 0; expA = 0; expTag = "R2";
    if (rq) begin
      seg = va >> 13;
      if (!enM) begin
        expTag = "R3";
        expA = (seg == 7) ? (32'h3FE000 | (va & 32'h1FFF)) : va;
      end else begin
        idx = (u ? 16 : 0) + ((dsp && (u ? sepU : sepK)) ? 8 : 0) + seg;
        par = parM[idx]; pdr = pdrM[idx];
        blk = (va >> 6) & 32'h7F; len = (pdr >> 8) & 32'h7F;
        dir = pdr[3]; acc = pdr & 7;
        lenOk = dir ? (blk >= len) : (blk <= len);
        accOk = (acc == 5 || acc == 6) || ((acc == 1 || acc == 2) && !w);
        if (!lenOk) begin expF = 1; expTag = dir ? "R6" : "R5"; end
        else if (!accOk) begin expF = 1; expTag = "R7"; end
        else begin expTag = "R4"; expA = (par * 64 + (va & 32'h1FFF)) & 32'h3FFFFF; end
      end
    end
    if (tagIn != "") expTag = tagIn;
  endfunction

  function automatic void applyWrite(bit wr, bit [6:0] a, bit [15:0] d);
    if (!wr) return;
    if (!a[6]) begin
      if (a[5]) pdrM[a[4:0]] = d; else parM[a[4:0]] = d;
    end else if (a == 7'h40) enM = d[0];
    else if (a == 7'h41) begin sepU = d[0]; sepK = d[2]; end
  endfunction

  task automatic compare();
    vectors++;
    if (rspValid !== expV || rspFault !== expF || rspPaddr !== 22'(expA)) begin
      errors++;
      $display("FAIL %s: actual v=%0b f=%0b pa=%h expected v=%0b f=%0b pa=%h",
               expTag, rspValid, rspFault, rspPaddr, expV, expF, 22'(expA));
    end
  endtask

  task automatic cyc(bit wr, bit [6:0] a, bit [15:0] d, bit rq, bit [15:0] va,
                     bit u, bit dsp, bit w, string tag);
    regWrEn = wr; regAddr = a; regWrData = d;
    reqValid = rq; reqVaddr = va; reqUser = u; reqData = dsp; reqWrite = w;
    predict(rq, va, u, dsp, w, tag);
    applyWrite(wr, a, d);
    @(negedge clk);
    compare();
  endtask

  task automatic wrReg(bit [6:0] a, bit [15:0] d);
    cyc(1, a, d, 0, 0, 0, 0, 0, "R11");
  endtask

  task automatic req(bit [15:0] va, bit u, bit dsp, bit w, string tag);
    cyc(0, 0, 0, 1, va, u, dsp, w, tag);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin parM[i] = 0; pdrM[i] = 0; end
    enM = 0; sepU = 0; sepK = 0;
    repeat (2) @(negedge clk);
    expV = 0; expF = 0; expA = 0; expTag = "R1";
    compare();                               // R1 during reset
    rstN = 1'b1;
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R1");       // R1 after release
    // R3 pass-through
    req(16'h1234, 0, 0, 0, "R3");
    req(16'hE005, 1, 1, 1, "R3");
    req(16'hDFFF, 0, 0, 1, "R3");
    req(16'hFFFF, 0, 0, 0, "R3");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R2");
    // program kernel I-space, full length, read/write
    for (int s = 0; s < 8; s++) begin
      wrReg(mapA(0, 0, 0, s), 16'(s * 16'h0100 + 3));
      wrReg(mapA(1, 0, 0, s), 16'h7F06);
    end
    wrReg(7'h40, 16'h0001);
    req(16'h0000, 0, 0, 0, "R4");
    req(16'h3ABC, 0, 0, 1, "R4");
    req(16'hFFFF, 0, 0, 0, "R4");
    wrReg(mapA(0, 0, 0, 5), 16'hFFFF);       // wrap of the sum, R4
    req(16'hBFFF, 0, 0, 0, "R4");
    // R5 upward, length 0
    wrReg(mapA(1, 0, 0, 1), 16'h0006);
    req(16'h203F, 0, 0, 0, "R5");
    req(16'h2040, 0, 0, 0, "R5");
    wrReg(mapA(1, 0, 0, 1), 16'h1006);
    req(16'h2400, 0, 0, 0, "R5");
    req(16'h2440, 0, 0, 1, "R8");
    // R6 downward
    wrReg(mapA(1, 0, 0, 2), 16'h7F0E);
    req(16'h5FC0, 0, 0, 0, "R6");
    req(16'h5FBF, 0, 0, 0, "R6");
    wrReg(mapA(1, 0, 0, 2), 16'h000E);
    req(16'h4000, 0, 0, 1, "R6");
    // R7 access codes on segment 3
    for (int c = 0; c < 8; c++) begin
      wrReg(mapA(1, 0, 0, 3), 16'(16'h7F00 | c));
      req(16'h6100, 0, 0, 0, "R7");
      req(16'h6100, 0, 0, 1, "R7");
    end
    // R9 user set
    wrReg(mapA(0, 1, 0, 0), 16'h0800);
    wrReg(mapA(1, 1, 0, 0), 16'h7F06);
    req(16'h0010, 1, 0, 0, "R9");
    req(16'h0010, 0, 0, 0, "R9");
    // R10 separation
    wrReg(mapA(0, 0, 1, 0), 16'h0400);
    wrReg(mapA(1, 0, 1, 0), 16'h7F06);
    wrReg(mapA(0, 1, 1, 0), 16'h0C00);
    wrReg(mapA(1, 1, 1, 0), 16'h7F06);
    req(16'h0020, 0, 1, 0, "R10");
    req(16'h0020, 1, 1, 0, "R10");
    wrReg(7'h41, 16'h0004);
    req(16'h0020, 0, 1, 0, "R10");
    req(16'h0020, 1, 1, 0, "R10");
    wrReg(7'h41, 16'h0001);
    req(16'h0020, 0, 1, 0, "R10");
    req(16'h0020, 1, 1, 0, "R10");
    req(16'h0020, 1, 0, 0, "R10");
    // R11 same-cycle collision
    wrReg(mapA(0, 0, 0, 4), 16'h0100);
    cyc(1, mapA(0, 0, 0, 4), 16'h0200, 1, 16'h8008, 0, 0, 0, "R11");
    req(16'h8008, 0, 0, 0, "R11");
    cyc(1, 7'h40, 16'h0000, 1, 16'h8008, 0, 0, 0, "R11");
    req(16'h8008, 0, 0, 0, "R11");
    // R12 ignored addresses
    wrReg(7'h42, 16'hFFFF);
    wrReg(7'h7F, 16'hFFFF);
    req(16'h8008, 0, 0, 0, "R12");
    wrReg(7'h41, 16'h0000);
    wrReg(7'h40, 16'h0001);
    wrReg(7'h43, 16'h0000);
    req(16'h0020, 1, 1, 0, "R12");
    // random mix
    for (int n = 0; n < 600; n++) begin
      bit wr, rq;
      bit [6:0] a;
      int unsigned r;
      r  = $urandom;
      wr = (r % 3) == 0;
      a  = ((r >> 4) % 16 == 0) ? 7'(7'h40 + ((r >> 8) % 4)) : 7'((r >> 8) % 64);
      rq = ((r >> 16) % 4) != 0;
      cyc(wr, a, 16'($urandom), rq, 16'($urandom), r[20], r[21], r[22], "");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule